// File: doc/BRIEF.md
# IOMMU Context Register Bank

This block holds the software-visible state of an I/O memory management unit for a fixed number of translation contexts. Each context has a control word, a 40-bit page-table base split over two words, a fault status word and a 64-bit captured fault address. Software reaches the bank through a 32-bit memory-mapped port. Every context uses a 64-byte window, and the context index comes from the address bits above the window offset.

The bank runs the TLB invalidation handshake. When software sets the flush bit of a context, the bank sends a one-cycle request carrying the context index to the TLB. The flush bit then works as a busy flag until the TLB returns a done for that context. The translation engine reports faults on a separate port. The bank keeps only the first fault of each context until software clears it by writing zero to the status word. It raises a single interrupt line for any context whose interrupt enable is set and that holds a fault.

A parameter selects one of two variants. The root variant stores every control field. The cache variant stores only the three common control bits.

Top module: `iommu_ctx_regs`

## Requirements
- R1: Context index = reg_addr[ADDR_W-1:6]. Offset = reg_addr[5:0]. The offsets are 0x00 control, 0x10 table base low, 0x14 table base high, 0x20 status, 0x30 fault address low and 0x34 fault address high. Any other offset reads zero and ignores writes. After reset every register reads zero, and irq and flush_req are low.
- R2: In the root variant the control word stores bits 0 (translate enable), 2 (interrupt enable), 3, 5:4, 16, 17 and 29. Bit 1 is the flush flag. All other bits read zero.
- R3: In the cache variant the control word stores only bits 2:0. All other written bits are dropped and read zero.
- R4: Writing control with bit 1 = 1 sets that context's flush flag. Writing control with bit 1 = 0 leaves a pending flush flag set.
- R5: flush_done with flush_done_ctx = n clears the flush flag of context n only, one cycle later. If a set and a done reach the same context in the same cycle, the set wins.
- R6: A control write with bit 1 = 1 to a context whose flush flag is clear makes flush_req high for exactly the next cycle, with flush_ctx = that context. The same write to a context already flushing issues no request.
- R7: Table base low keeps bits 31:12 only. Table base high keeps bits 7:0 only.
- R8: A fault reported with fault_valid on a context with no error flag set is stored in status. The flag mapping is fault_flags[0]→bit 0 (translation), [1]→bit 1 (permission), [2]→bit 2 (walk abort) and [3]→bit 4 (multiple hit). fault_code goes to bits 10:8 and fault_level to bits 13:12. fault_addr goes to the two address words. The result is visible the next cycle.
- R9: While any of status bits 0, 1, 2 or 4 is set, later faults on that context change neither status nor address.
- R10: Writing zero to status clears status and both fault address words. A nonzero write to status has no effect.
- R11: irq is high exactly when some context has control bit 2 set and any of status bits 0, 1, 2 or 4 set.
- R12: If a zero write to status and a fault on the same context fall in the same cycle, the new fault is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address: context index above a 6-bit offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| flush_req | output | 1 | One-cycle TLB invalidation request |
| flush_ctx | output | CTX_W | Context of the flush request |
| flush_done | input | 1 | TLB reports an invalidation complete |
| flush_done_ctx | input | CTX_W | Context whose invalidation completed |
| fault_valid | input | 1 | Fault report strobe from the translation engine |
| fault_ctx | input | CTX_W | Context of the fault |
| fault_flags | input | 4 | {multi-hit, walk abort, permission, translation} |
| fault_code | input | 3 | Error code of the fault |
| fault_level | input | 2 | Table level of the fault |
| fault_addr | input | 64 | Faulting input address |
| irq | output | 1 | Combined fault interrupt |

## Verification
The hardest case to reach is a software clear and a new fault landing on the same context in the same clock. The bench gets there by driving the zero write to status and fault_valid in one cycle, with a fault already held in that context. It then checks that the new report, not the cleared state, is left. The flush flag is also hard to observe, because it is held up by an outstanding done. The bench holds done back and rewrites the control word with flush clear. It also sends a done for a different context, and checks after each step that the flag reads back still set.

// File: rtl/iommu_ctx_pkg.sv
package iommu_ctx_pkg;

   localparam int WORD_W    = 32;
   localparam int WIN_BITS  = 6;

   localparam logic [5:0] OFS_CTRL  = 6'h00;
   localparam logic [5:0] OFS_TBLO  = 6'h10;
   localparam logic [5:0] OFS_TBHI  = 6'h14;
   localparam logic [5:0] OFS_STAT  = 6'h20;
   localparam logic [5:0] OFS_FALO  = 6'h30;
   localparam logic [5:0] OFS_FAHI  = 6'h34;

   localparam int BIT_FLUSH = 1;
   localparam int BIT_IRQEN = 2;

   localparam logic [31:0] CTRL_ROOT_KEEP  = 32'h2003_003D;
   localparam logic [31:0] CTRL_CACHE_KEEP = 32'h0000_0005;
   localparam logic [31:0] TBLO_KEEP       = 32'hFFFF_F000;
   localparam logic [31:0] TBHI_KEEP       = 32'h0000_00FF;
   localparam logic [31:0] STAT_ERR_FLAGS  = 32'h0000_0017;

   function automatic logic [31:0] pack_status(input logic [3:0] flags,
                                               input logic [2:0] code,
                                               input logic [1:0] level);
      logic [31:0] s;
      s = '0;
      s[2:0]   = flags[2:0];
      s[4]     = flags[3];
      s[10:8]  = code;
      s[13:12] = level;
      return s;
   endfunction

endpackage

// File: rtl/iommu_ctx_ctrl.sv
module iommu_ctx_ctrl
   import iommu_ctx_pkg::*;
#(
   parameter bit IS_ROOT = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_ctrl,
   input  logic        wr_tblo,
   input  logic        wr_tbhi,
   input  logic [31:0] wdata,
   input  logic        done_hit,
   output logic [31:0] ctrl_rd,
   output logic [31:0] tblo_rd,
   output logic [31:0] tbhi_rd,
   output logic        flush_busy,
   output logic        irq_en
);

   logic [31:0] keep_mask;
   logic [31:0] ctrl_q;
   logic        busy_q;
   logic        set_flush;

   if (IS_ROOT) begin : g_root
      assign keep_mask = CTRL_ROOT_KEEP;
   end else begin : g_cache
      assign keep_mask = CTRL_CACHE_KEEP;
   end

   assign set_flush = wr_ctrl && wdata[BIT_FLUSH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         busy_q  <= 1'b0;
         tblo_rd <= '0;
         tbhi_rd <= '0;
      end else begin
         if (wr_ctrl) ctrl_q  <= wdata & keep_mask;
         if (wr_tblo) tblo_rd <= wdata & TBLO_KEEP;
         if (wr_tbhi) tbhi_rd <= wdata & TBHI_KEEP;
         if (set_flush)     busy_q <= 1'b1;
         else if (done_hit) busy_q <= 1'b0;
      end
   end

   always_comb begin
      ctrl_rd            = ctrl_q;
      ctrl_rd[BIT_FLUSH] = busy_q;
   end

   assign flush_busy = busy_q;
   assign irq_en     = ctrl_q[BIT_IRQEN];

   // R4: a flush write always leaves the flag set
   p_flush_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      set_flush |=> flush_busy);

   // R5: a done without a competing set clears the flag
   p_flush_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (done_hit && !set_flush) |=> !flush_busy);

endmodule

// File: rtl/iommu_ctx_fault.sv
module iommu_ctx_fault
   import iommu_ctx_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_stat,
   input  logic [31:0] wdata,
   input  logic        cap_hit,
   input  logic [3:0]  flags,
   input  logic [2:0]  code,
   input  logic [1:0]  level,
   input  logic [63:0] faddr,
   output logic [31:0] stat_rd,
   output logic [31:0] falo_rd,
   output logic [31:0] fahi_rd,
   output logic        err_any
);

   logic [31:0] stat_q;
   logic [63:0] addr_q;
   logic        clr;
   logic        take;

   assign clr     = wr_stat && (wdata == '0);
   assign err_any = |(stat_q & STAT_ERR_FLAGS);
   assign take    = cap_hit && (clr || !err_any);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stat_q <= '0;
         addr_q <= '0;
      end else if (take) begin
         stat_q <= pack_status(flags, code, level);
         addr_q <= faddr;
      end else if (clr) begin
         stat_q <= '0;
         addr_q <= '0;
      end
   end

   assign stat_rd = stat_q;
   assign falo_rd = addr_q[31:0];
   assign fahi_rd = addr_q[63:32];

   // R9: a held fault is not overwritten
   p_first_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (err_any && !clr) |=> ($stable(stat_q) && $stable(addr_q)));

   // R10: a zero write with no fault wipes status and address
   p_clear_wipes_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !cap_hit) |=> (stat_q == '0 && addr_q == '0));

endmodule

// File: rtl/iommu_ctx_regs.sv
module iommu_ctx_regs
   import iommu_ctx_pkg::*;
#(
   parameter int NUM_CTX = 8,
   parameter bit IS_ROOT = 1'b1,
   parameter int CTX_W   = $clog2(NUM_CTX),
   parameter int ADDR_W  = CTX_W + WIN_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              flush_req,
   output logic [CTX_W-1:0]  flush_ctx,
   input  logic              flush_done,
   input  logic [CTX_W-1:0]  flush_done_ctx,
   input  logic              fault_valid,
   input  logic [CTX_W-1:0]  fault_ctx,
   input  logic [3:0]        fault_flags,
   input  logic [2:0]        fault_code,
   input  logic [1:0]        fault_level,
   input  logic [63:0]       fault_addr,
   output logic              irq
);

   if (NUM_CTX < 2 || (NUM_CTX & (NUM_CTX - 1)) != 0) begin : g_bad_ctx
      $error("NUM_CTX must be a power of two of at least 2");
   end
   if (NUM_CTX > 16) begin : g_too_many
      $error("NUM_CTX above 16 exceeds the table select field");
   end
   if (ADDR_W != CTX_W + WIN_BITS || CTX_W != $clog2(NUM_CTX)) begin : g_bad_w
      $error("CTX_W and ADDR_W must keep their derived values");
   end

   logic [CTX_W-1:0] ctx_sel;
   logic [5:0]       ofs;
   logic [31:0]      ctrl_v [NUM_CTX];
   logic [31:0]      tblo_v [NUM_CTX];
   logic [31:0]      tbhi_v [NUM_CTX];
   logic [31:0]      stat_v [NUM_CTX];
   logic [31:0]      falo_v [NUM_CTX];
   logic [31:0]      fahi_v [NUM_CTX];
   logic [NUM_CTX-1:0] busy_v;
   logic [NUM_CTX-1:0] irqen_v;
   logic [NUM_CTX-1:0] err_v;
   logic             issue;

   assign ctx_sel = reg_addr[ADDR_W-1:WIN_BITS];
   assign ofs     = reg_addr[WIN_BITS-1:0];

   for (genvar i = 0; i < NUM_CTX; i++) begin : g_ctx
      logic sel;
      assign sel = reg_wr && (ctx_sel == CTX_W'(i));

      iommu_ctx_ctrl #(.IS_ROOT(IS_ROOT)) i_ctrl (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_ctrl   (sel && ofs == OFS_CTRL),
         .wr_tblo   (sel && ofs == OFS_TBLO),
         .wr_tbhi   (sel && ofs == OFS_TBHI),
         .wdata     (reg_wdata),
         .done_hit  (flush_done && flush_done_ctx == CTX_W'(i)),
         .ctrl_rd   (ctrl_v[i]),
         .tblo_rd   (tblo_v[i]),
         .tbhi_rd   (tbhi_v[i]),
         .flush_busy(busy_v[i]),
         .irq_en    (irqen_v[i])
      );

      iommu_ctx_fault i_fault (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_stat (sel && ofs == OFS_STAT),
         .wdata   (reg_wdata),
         .cap_hit (fault_valid && fault_ctx == CTX_W'(i)),
         .flags   (fault_flags),
         .code    (fault_code),
         .level   (fault_level),
         .faddr   (fault_addr),
         .stat_rd (stat_v[i]),
         .falo_rd (falo_v[i]),
         .fahi_rd (fahi_v[i]),
         .err_any (err_v[i])
      );
   end

   always_comb begin
      unique case (ofs)
         OFS_CTRL: reg_rdata = ctrl_v[ctx_sel];
         OFS_TBLO: reg_rdata = tblo_v[ctx_sel];
         OFS_TBHI: reg_rdata = tbhi_v[ctx_sel];
         OFS_STAT: reg_rdata = stat_v[ctx_sel];
         OFS_FALO: reg_rdata = falo_v[ctx_sel];
         OFS_FAHI: reg_rdata = fahi_v[ctx_sel];
         default:  reg_rdata = '0;
      endcase
   end

   assign issue = reg_wr && (ofs == OFS_CTRL) && reg_wdata[BIT_FLUSH]
                  && !busy_v[ctx_sel];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flush_req <= 1'b0;
         flush_ctx <= '0;
      end else begin
         flush_req <= issue;
         if (issue) flush_ctx <= ctx_sel;
      end
   end

   assign irq = |(irqen_v & err_v);

   // R6: an issued request always refers to a context that is flushing
   p_req_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
      flush_req |-> busy_v[flush_ctx]);

   // R6: a busy context never gets a second request
   p_no_dup_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && ofs == OFS_CTRL && busy_v[ctx_sel] && !flush_done) |=> !flush_req);

endmodule

// File: tb/test_iommu_ctx_regs.sv
module test_iommu_ctx_regs;

   localparam int NC = 8;
   localparam int CW = 3;
   localparam int AW = CW + 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic [31:0]   reg_wdata = '0;
   logic [31:0]   rdata, rdata_c;
   logic          flush_req, flush_req_c;
   logic [CW-1:0] flush_ctx, flush_ctx_c;
   logic          flush_done = 1'b0;
   logic [CW-1:0] flush_done_ctx = '0;
   logic          fault_valid = 1'b0;
   logic [CW-1:0] fault_ctx = '0;
   logic [3:0]    fault_flags = '0;
   logic [2:0]    fault_code = '0;
   logic [1:0]    fault_level = '0;
   logic [63:0]   fault_addr = '0;
   logic          irq, irq_c;

   int total = 0;
   int bad = 0;
   bit done_flag = 1'b0;

   always #10 clk = ~clk;

   iommu_ctx_regs #(.NUM_CTX(NC), .IS_ROOT(1'b1)) i_iommu_ctx_regs (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(rdata), .flush_req(flush_req),
      .flush_ctx(flush_ctx), .flush_done(flush_done),
      .flush_done_ctx(flush_done_ctx), .fault_valid(fault_valid),
      .fault_ctx(fault_ctx), .fault_flags(fault_flags),
      .fault_code(fault_code), .fault_level(fault_level),
      .fault_addr(fault_addr), .irq(irq));

   iommu_ctx_regs #(.NUM_CTX(NC), .IS_ROOT(1'b0)) i_iommu_ctx_regs_c (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(rdata_c), .flush_req(flush_req_c),
      .flush_ctx(flush_ctx_c), .flush_done(flush_done),
      .flush_done_ctx(flush_done_ctx), .fault_valid(fault_valid),
      .fault_ctx(fault_ctx), .fault_flags(fault_flags),
      .fault_code(fault_code), .fault_level(fault_level),
      .fault_addr(fault_addr), .irq(irq_c));

   function automatic logic [AW-1:0] ad(input int ctx, input int ofs);
      return AW'(ctx * 64 + ofs);
   endfunction

   function automatic logic [31:0] exp_stat(input logic [3:0] f,
                                            input logic [2:0] c,
                                            input logic [1:0] l);
      return (32'(l) << 12) | (32'(c) << 8) | (32'(f[3]) << 4) | 32'(f[2:0]);
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input int ctx, input int ofs, input logic [31:0] d);
      reg_wr = 1'b1; reg_addr = ad(ctx, ofs); reg_wdata = d;
      @(posedge clk); @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input int ctx, input int ofs, output logic [31:0] d,
                     output logic [31:0] dc);
      reg_addr = ad(ctx, ofs);
      #1;
      d = rdata; dc = rdata_c;
   endtask

   task automatic fault(input int ctx, input logic [3:0] f, input logic [2:0] c,
                        input logic [1:0] l, input logic [63:0] a);
      fault_valid = 1'b1; fault_ctx = CW'(ctx); fault_flags = f;
      fault_code = c; fault_level = l; fault_addr = a;
      @(posedge clk); @(negedge clk);
      fault_valid = 1'b0;
   endtask

   task automatic t_reset;
      logic [31:0] d, dc;
      rd(0, 'h00, d, dc); chk("R1 reset ctrl", d, 0);
      rd(4, 'h20, d, dc); chk("R1 reset status", d, 0);
      rd(7, 'h34, d, dc); chk("R1 reset addr hi", d, 0);
      chk("R1 reset irq", irq, 0);
      chk("R1 reset flush_req", flush_req, 0);
   endtask

   task automatic t_map;
      logic [31:0] d, dc;
      wr(2, 'h04, 32'hFFFF_FFFF);
      rd(2, 'h04, d, dc); chk("R1 hole reads zero", d, 0);
      rd(2, 'h00, d, dc); chk("R1 hole write no effect on ctrl", d, 0);
      wr(2, 'h3C, 32'h1234_5678);
      rd(2, 'h3C, d, dc); chk("R1 hole 0x3C reads zero", d, 0);
   endtask

   task automatic t_masks;
      logic [31:0] d, dc;
      wr(3, 'h00, 32'hFFFF_FFFD);
      rd(3, 'h00, d, dc);
      chk("R2 root control keep", d, 32'h2003_003D);
      chk("R3 cache control keep", dc, 32'h0000_0005);
      chk("R2 no flush request on bit1=0", flush_req, 0);
      wr(3, 'h00, 32'h0);
      rd(3, 'h00, d, dc); chk("R2 control cleared", d, 0);
   endtask

   task automatic t_ttb;
      logic [31:0] d, dc;
      wr(5, 'h10, 32'hABCD_E123);
      wr(5, 'h14, 32'h0001_2345);
      rd(5, 'h10, d, dc); chk("R7 table base low", d, 32'hABCD_E000);
      rd(5, 'h14, d, dc); chk("R7 table base high", d, 32'h0000_0045);
      rd(4, 'h10, d, dc); chk("R1 neighbour context untouched", d, 0);
   endtask

   task automatic t_flush;
      logic [31:0] d, dc;
      wr(6, 'h00, 32'h3);
      chk("R6 flush_req pulse", flush_req, 1);
      chk("R6 flush_ctx", flush_ctx, 6);
      rd(6, 'h00, d, dc); chk("R4 flag set", d, 32'h3);
      @(posedge clk); @(negedge clk);
      chk("R6 pulse one cycle", flush_req, 0);
      wr(6, 'h00, 32'h3);
      chk("R6 no request while busy", flush_req, 0);
      wr(6, 'h00, 32'h1);
      rd(6, 'h00, d, dc); chk("R4 zero write keeps flag", d, 32'h3);
      flush_done = 1'b1; flush_done_ctx = 3'd5;
      @(posedge clk); @(negedge clk);
      flush_done = 1'b0;
      rd(6, 'h00, d, dc); chk("R5 other context done ignored", d, 32'h3);
      flush_done = 1'b1; flush_done_ctx = 3'd6;
      @(posedge clk); @(negedge clk);
      flush_done = 1'b0;
      rd(6, 'h00, d, dc); chk("R5 done clears flag", d, 32'h1);
      wr(6, 'h00, 32'h0);
   endtask

   task automatic t_fault;
      logic [31:0] d, dc;
      wr(1, 'h00, 32'h4);
      fault(1, 4'b0010, 3'd4, 2'd2, 64'h0000_00AB_1234_5678);
      rd(1, 'h20, d, dc); chk("R8 status captured", d, exp_stat(4'b0010, 3'd4, 2'd2));
      rd(1, 'h30, d, dc); chk("R8 addr low", d, 32'h1234_5678);
      rd(1, 'h34, d, dc); chk("R8 addr high", d, 32'h0000_00AB);
      chk("R11 irq on enabled fault", irq, 1);
      fault(1, 4'b0001, 3'd1, 2'd1, 64'h1111_2222_3333_4444);
      rd(1, 'h20, d, dc); chk("R9 status kept", d, exp_stat(4'b0010, 3'd4, 2'd2));
      rd(1, 'h30, d, dc); chk("R9 addr kept", d, 32'h1234_5678);
      wr(1, 'h20, 32'h5);
      rd(1, 'h20, d, dc); chk("R10 nonzero write ignored", d, exp_stat(4'b0010, 3'd4, 2'd2));
      wr(1, 'h20, 32'h0);
      rd(1, 'h20, d, dc); chk("R10 status cleared", d, 0);
      rd(1, 'h30, d, dc); chk("R10 addr low cleared", d, 0);
      rd(1, 'h34, d, dc); chk("R10 addr high cleared", d, 0);
      chk("R11 irq drops after clear", irq, 0);
   endtask

   task automatic t_irq_race;
      logic [31:0] d, dc;
      fault(7, 4'b1000, 3'd1, 2'd1, 64'h0000_0000_0000_0099);
      rd(7, 'h20, d, dc); chk("R8 multi-hit maps to bit 4", d, 32'h0000_1110);
      chk("R11 no irq without enable", irq, 0);
      wr(7, 'h00, 32'h4);
      chk("R11 irq after enable", irq, 1);
      reg_wr = 1'b1; reg_addr = ad(7, 'h20); reg_wdata = 32'h0;
      fault_valid = 1'b1; fault_ctx = 3'd7; fault_flags = 4'b0100;
      fault_code = 3'd5; fault_level = 2'd3; fault_addr = 64'h55;
      @(posedge clk); @(negedge clk);
      reg_wr = 1'b0; fault_valid = 1'b0;
      rd(7, 'h20, d, dc); chk("R12 race keeps new fault", d, 32'h0000_3504);
      rd(7, 'h30, d, dc); chk("R12 race new address", d, 32'h55);
      chk("R12 irq still high", irq, 1);
      wr(7, 'h20, 32'h0);
      chk("R11 irq low after clear", irq, 0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done_flag) begin
         bad++; total++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_map();
      t_masks();
      t_ttb();
      t_flush();
      t_fault();
      t_irq_race();
      done_flag = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule